// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the serial slave front end of a 2 KiB byte-addressed memory. The memory is held on chip as a register array. The block oversamples the serial clock, data-in, chip-select and pause inputs on its own system clock. It decodes an 8-bit command, collects a 16-bit address when the command needs one, and then either streams data out or gathers data bytes into a one-page staging buffer. On the serial data output it drives a value together with a separate output-enable, so the pin can be tri-stated.

Bus sessions end with chip-select rising, and the block judges only at that moment whether the command was framed correctly. If it was, the block raises a single-cycle request towards the status and protection controller. There are four requests: set the write-enable latch, clear it, write the status byte, or program the staged page. The controller answers a page request through `write_allow` in the same cycle. Only when that answer is yes is the staged page copied into the array. The controller supplies the status byte that is read out. Write timing, cell programming and block protection belong to the controller, not here.

Top module: `spi_mem_cmd_engine`

## Requirements
- R1: After reset, no command has any effect until chip-select has been seen high and then low. `so_oe` is low whenever chip-select is high.
- R2: Command 0x06 yields one `set_wel` pulse and command 0x04 yields one `clr_wel` pulse. Each pulse is given only if chip-select rises right after the eighth bit. If any further clock edge arrives first, the command is dropped.
- R3: Command 0x05 shifts `status_in` out MSB first. The byte repeats for as long as clocks continue.
- R4: Command 0x03 is followed by a 16-bit address, and only its low 11 bits are used. Data bytes then stream out MSB first, with each bit changing only after a falling SCK edge. The address increments per byte and wraps from 0x7FF to 0x000. SCK idle-low and idle-high framing both work.
- R5: Command 0x02 is followed by a 16-bit address and data bytes. Each byte lands at the next address inside the same 32-byte page: the low 5 bits wrap and the page bits stay fixed. A later byte replaces an earlier one at the same slot.
- R6: A page write gives one `mem_wr` pulse, with `mem_wr_addr` equal to the start address. This happens only when chip-select rises after at least one complete data byte and before any further clock edge. Otherwise there is no pulse and no array change.
- R7: During a `mem_wr` pulse, the staged bytes are copied into the array only if `write_allow` is high in that cycle.
- R8: Command 0x01 followed by exactly one byte yields one `sr_wr` pulse, with `sr_wdata` equal to that byte.
- R9: Pulling `hold_n` low while SCK is low pauses the session. While paused, SCK and SI are ignored and `so_oe` is low. Raising `hold_n` while SCK is low resumes at the exact bit where the session stopped.
- R10: Any other command value gives no request and no output drive until the next deselect.
- R11: `so_oe` is high only while selected, not paused, and in the data phase of command 0x03 or 0x05.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data in, sampled on rising SCK |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause request |
| status_in | input | 8 | Status byte supplied by the controller for read-out |
| write_allow | input | 1 | Controller verdict on the page request in the `mem_wr` cycle |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pin |
| set_wel | output | 1 | Single-cycle request to set the write-enable latch |
| clr_wel | output | 1 | Single-cycle request to clear the write-enable latch |
| sr_wr | output | 1 | Single-cycle request to write the status byte |
| sr_wdata | output | 8 | Status byte carried with `sr_wr` |
| mem_wr | output | 1 | Single-cycle request to program the staged page |
| mem_wr_addr | output | 11 | Start address of the staged page write |

## Verification
Two events can land in the same sampled SCK low phase. One is a falling SCK edge that shifts the next output bit. The other is the start of a pause, which must freeze all later bits. The bench pauses a read mid-byte just after such a falling edge and toggles SCK and SI while paused. It then requires the enable to be low during the pause, and the reassembled byte to match the model with no bit skipped or repeated. A second case puts the deselect decision next to the byte-completing edge. Chip-select is raised either right after bit 0 or a few bits later, and the bench compares the request pulses and the array readback against the model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] CMD_WEL_SET = 8'h06;
  localparam logic [7:0] CMD_WEL_CLR = 8'h04;
  localparam logic [7:0] CMD_SR_RD   = 8'h05;
  localparam logic [7:0] CMD_SR_WR   = 8'h01;
  localparam logic [7:0] CMD_RD      = 8'h03;
  localparam logic [7:0] CMD_WR      = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_RDATA, PH_RSTAT, PH_WDATA, PH_SRDATA, PH_END, PH_IGNORE
  } phase_e;

  typedef enum logic [1:0] {
    FIN_WEL_SET, FIN_WEL_CLR, FIN_SR_WR
  } finish_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int               WIDTH   = 4,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_page_buf.sv
module spi_page_buf #(
  parameter int PAGE_BYTES = 32,
  parameter int SLOT_W     = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    we,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [7:0]              wdata,
  output logic [PAGE_BYTES*8-1:0] data_o,
  output logic [PAGE_BYTES-1:0]   valid_o
);
  logic [7:0]            bytes_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  always_ff @(posedge clk)
    if (we) bytes_q[slot] <= wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   valid_q <= '0;
    else if (clr) valid_q <= '0;
    else if (we)  valid_q[slot] <= 1'b1;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign data_o[g*8 +: 8] = bytes_q[g];
  end
  assign valid_o = valid_q;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32,
  parameter int SLOT_W     = $clog2(PAGE_BYTES)
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  input  logic                     pg_wr,
  input  logic [ADDR_W-SLOT_W-1:0] pg_idx,
  input  logic [PAGE_BYTES*8-1:0]  pg_data,
  input  logic [PAGE_BYTES-1:0]    pg_valid
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (pg_wr)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pg_valid[i]) mem[{pg_idx, SLOT_W'(i)}] <= pg_data[i*8 +: 8];

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spi_mem_cmd_engine.sv
module spi_mem_cmd_engine
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              si,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic [7:0]        status_in,
  input  logic              write_allow,
  output logic              so,
  output logic              so_oe,
  output logic              set_wel,
  output logic              clr_wel,
  output logic              sr_wr,
  output logic [7:0]        sr_wdata,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_wr_addr
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - 8;

  logic s_sck, s_si, s_cs, s_hold;
  spi_in_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hold_n, cs_n, si, sck}), .q({s_hold, s_cs, s_si, s_sck}));

  phase_e            phase_q, phase_d;
  finish_e           fin_q, fin_d;
  logic              sck_q, cs_q, active_q, active_d, paused_q, paused_d;
  logic [2:0]        bit_q, bit_d;
  logic [6:0]        sh_q, sh_d;
  logic              hi_sel_q, hi_sel_d, is_wr_q, is_wr_d, bnd_q, bnd_d;
  logic [ADDR_W-1:0] addr_q, addr_d, start_q, start_d, rd_addr;
  logic [7:0]        osr_q, osr_d, sr_q, sr_d, rd_data, byte_val;
  logic              so_q, so_d;
  logic              set_q, set_d, clr_q, clr_d, srw_q, srw_d, mw_q, mw_d;
  logic              buf_clr, buf_we;
  logic [PAGE_BYTES*8-1:0] pg_data;
  logic [PAGE_BYTES-1:0]   pg_valid;

  wire live      = active_q & ~paused_q & ~s_cs;
  wire sck_rise  = live & s_sck & ~sck_q;
  wire sck_fall  = live & ~s_sck & sck_q;
  wire cs_fall   = ~s_cs & cs_q;
  wire cs_rise   = s_cs & ~cs_q;
  wire byte_done = sck_rise & (bit_q == 3'd7);
  wire out_phase = (phase_q == PH_RDATA) | (phase_q == PH_RSTAT);

  assign byte_val = {sh_q, s_si};
  assign rd_addr  = (phase_q == PH_ADDR) ? {addr_q[ADDR_W-1:8], byte_val} : addr_q;

  always_comb begin
    phase_d  = phase_q;  fin_d    = fin_q;    bit_d   = bit_q;    sh_d = sh_q;
    hi_sel_d = hi_sel_q; is_wr_d  = is_wr_q;  bnd_d   = bnd_q;
    addr_d   = addr_q;   start_d  = start_q;  osr_d   = osr_q;    sr_d = sr_q;
    so_d     = so_q;     active_d = active_q; paused_d = paused_q;
    set_d = 1'b0; clr_d = 1'b0; srw_d = 1'b0; mw_d = 1'b0;
    buf_clr = 1'b0; buf_we = 1'b0;

    if (s_cs)         active_d = 1'b0;
    else if (cs_fall) active_d = 1'b1;
    if (s_cs)         paused_d = 1'b0;
    else if (!s_sck)  paused_d = ~s_hold;

    if (s_cs) begin
      phase_d = PH_CMD; bit_d = '0; bnd_d = 1'b0; hi_sel_d = 1'b0;
      if (cs_rise && active_q && bnd_q) begin
        if (phase_q == PH_WDATA) mw_d = 1'b1;
        else if (phase_q == PH_END) begin
          set_d = (fin_q == FIN_WEL_SET);
          clr_d = (fin_q == FIN_WEL_CLR);
          srw_d = (fin_q == FIN_SR_WR);
        end
      end
    end else if (sck_rise) begin
      sh_d  = byte_val[6:0];
      bit_d = bit_q + 3'd1;
      bnd_d = 1'b0;
      if (phase_q == PH_END) phase_d = PH_IGNORE;
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            if (byte_val == CMD_WEL_SET) begin
              phase_d = PH_END; fin_d = FIN_WEL_SET; bnd_d = 1'b1;
            end else if (byte_val == CMD_WEL_CLR) begin
              phase_d = PH_END; fin_d = FIN_WEL_CLR; bnd_d = 1'b1;
            end else if (byte_val == CMD_SR_RD) begin
              phase_d = PH_RSTAT; osr_d = status_in;
            end else if (byte_val == CMD_SR_WR) begin
              phase_d = PH_SRDATA;
            end else if (byte_val == CMD_RD || byte_val == CMD_WR) begin
              phase_d = PH_ADDR; hi_sel_d = 1'b0;
              is_wr_d = (byte_val == CMD_WR);
              buf_clr = (byte_val == CMD_WR);
            end else begin
              phase_d = PH_IGNORE;
            end
          end
          PH_ADDR: begin
            if (!hi_sel_q) begin
              addr_d[ADDR_W-1:8] = byte_val[HI_W-1:0];
              hi_sel_d = 1'b1;
            end else if (is_wr_q) begin
              addr_d  = rd_addr;
              start_d = rd_addr;
              phase_d = PH_WDATA;
            end else begin
              osr_d   = rd_data;
              addr_d  = rd_addr + 1'b1;
              phase_d = PH_RDATA;
            end
          end
          PH_RDATA: begin
            osr_d  = rd_data;
            addr_d = addr_q + 1'b1;
          end
          PH_RSTAT: osr_d = status_in;
          PH_WDATA: begin
            buf_we = 1'b1;
            bnd_d  = 1'b1;
            addr_d[SLOT_W-1:0] = addr_q[SLOT_W-1:0] + 1'b1;
          end
          PH_SRDATA: begin
            sr_d = byte_val; phase_d = PH_END; fin_d = FIN_SR_WR; bnd_d = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (sck_fall && out_phase) begin
      so_d  = osr_q[7];
      osr_d = {osr_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;  fin_q <= FIN_WEL_SET; sck_q <= 1'b0; cs_q <= 1'b0;
      active_q <= 1'b0;   paused_q <= 1'b0;     bit_q <= '0;   sh_q <= '0;
      hi_sel_q <= 1'b0;   is_wr_q <= 1'b0;      bnd_q <= 1'b0;
      addr_q <= '0;       start_q <= '0;        osr_q <= '0;   sr_q <= '0;
      so_q <= 1'b0;       set_q <= 1'b0;        clr_q <= 1'b0;
      srw_q <= 1'b0;      mw_q <= 1'b0;
    end else begin
      phase_q <= phase_d; fin_q <= fin_d;       sck_q <= s_sck; cs_q <= s_cs;
      active_q <= active_d; paused_q <= paused_d; bit_q <= bit_d; sh_q <= sh_d;
      hi_sel_q <= hi_sel_d; is_wr_q <= is_wr_d;   bnd_q <= bnd_d;
      addr_q <= addr_d;   start_q <= start_d;   osr_q <= osr_d; sr_q <= sr_d;
      so_q <= so_d;       set_q <= set_d;       clr_q <= clr_d;
      srw_q <= srw_d;     mw_q <= mw_d;
    end
  end

  spi_page_buf #(.PAGE_BYTES(PAGE_BYTES), .SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
    .slot(addr_q[SLOT_W-1:0]), .wdata(byte_val),
    .data_o(pg_data), .valid_o(pg_valid));

  spi_mem_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SLOT_W(SLOT_W)) u_mem (
    .clk(clk), .rd_addr(rd_addr), .rd_data(rd_data),
    .pg_wr(mw_q & write_allow), .pg_idx(start_q[ADDR_W-1:SLOT_W]),
    .pg_data(pg_data), .pg_valid(pg_valid));

  assign so          = so_q;
  assign so_oe       = live & out_phase;
  assign set_wel     = set_q;
  assign clr_wel     = clr_q;
  assign sr_wr       = srw_q;
  assign sr_wdata    = sr_q;
  assign mem_wr      = mw_q;
  assign mem_wr_addr = start_q;
endmodule

// File: rtl/spi_mem_cmd_engine_chk.sv
module spi_mem_cmd_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_sync,
  input logic paused,
  input logic fall_ev,
  input logic so,
  input logic so_oe,
  input logic set_wel,
  input logic clr_wel,
  input logic sr_wr,
  input logic mem_wr
);
  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sync |-> !so_oe);  // R1

  AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_wel, clr_wel, sr_wr, mem_wr}));  // R2

  AST_REQ_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wel || clr_wel || sr_wr || mem_wr) |-> $past(cs_sync));  // R6

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);  // R6

  AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !so_oe);  // R9

  AST_SO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(so));  // R4
endmodule

bind spi_mem_cmd_engine spi_mem_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_sync(s_cs), .paused(paused_q),
  .fall_ev(sck_fall), .so(so), .so_oe(so_oe), .set_wel(set_wel),
  .clr_wel(clr_wel), .sr_wr(sr_wr), .mem_wr(mem_wr));

// File: tb/sim_spi_mem_cmd_engine.sv
module sim_spi_mem_cmd_engine;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst_n, sck, si, cs_n, hold_n, write_allow;
  logic [7:0] status_in;
  logic so, so_oe, set_wel, clr_wel, sr_wr, mem_wr;
  logic [7:0] sr_wdata;
  logic [10:0] mem_wr_addr;

  spi_mem_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
    .status_in(status_in), .write_allow(write_allow), .so(so), .so_oe(so_oe),
    .set_wel(set_wel), .clr_wel(clr_wel), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
    .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  int n_set = 0, n_clr = 0, n_sr = 0, n_mw = 0;
  logic [7:0]  last_sr;
  logic [10:0] last_mw;
  bit oe_seen = 0;
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];
  logic [7:0] exp_mem [2048];
  bit         exp_known [2048];
  bit         done = 0;

  always @(posedge clk) begin
    if (set_wel) n_set++;
    if (clr_wel) n_clr++;
    if (sr_wr) begin n_sr++; last_sr = sr_wdata; end
    if (mem_wr) begin n_mw++; last_mw = mem_wr_addr; end
    if (so_oe) oe_seen = 1;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start(input bit m3);
    sck = m3; tick(HALF); cs_n = 1'b0; tick(HALF);
  endtask

  task automatic stop(input bit m3);
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1; tick(2*HALF);
  endtask

  task automatic xbit(input bit b, output bit o);
    sck = 1'b0; si = b; tick(HALF);
    sck = 1'b1; tick(HALF/2); o = so; tick(HALF/2);
  endtask

  task automatic xbyte(input logic [7:0] b, output logic [7:0] o);
    for (int i = 7; i >= 0; i--) xbit(b[i], o[i]);
  endtask

  function automatic logic [10:0] page_slot(input logic [10:0] a, input int i);
    return {a[10:5], a[4:0] + 5'(i)};
  endfunction

  task automatic page_write(input logic [15:0] a, input int n);
    logic [7:0] d;
    start(0);
    xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
    stop(0);
    if (write_allow)
      for (int i = 0; i < n; i++) begin
        exp_mem[page_slot(a[10:0], i)]   = wbuf[i];
        exp_known[page_slot(a[10:0], i)] = 1;
      end
  endtask

  task automatic mem_read(input logic [15:0] a, input int n, input bit m3);
    logic [7:0] d;
    start(m3);
    xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
    stop(m3);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d, got;
    logic [15:0] a;
    int n, b0;
    bit ob;
    void'($urandom(32'h5EED_2024));
    rst_n = 0; sck = 0; si = 0; cs_n = 0; hold_n = 1;
    status_in = 8'hA5; write_allow = 1;
    tick(5); rst_n = 1; tick(4);
    chk(so_oe == 0, "R1", "so_oe after reset", so_oe, 0);
    // R1: selected since reset without a falling chip-select: ignored
    xbyte(8'h06, d); sck = 0; tick(HALF); cs_n = 1; tick(2*HALF);
    chk(n_set == 0, "R1", "set_wel without cs fall", n_set, 0);
    chk(so_oe == 0, "R1", "so_oe deselected", so_oe, 0);

    // R2: set and clear requests, and the dropped one
    start(0); xbyte(8'h06, d); stop(0);
    chk(n_set == 1, "R2", "set_wel count", n_set, 1);
    start(0); xbyte(8'h06, d); xbit(0, ob); stop(0);
    chk(n_set == 1, "R2", "extra clock drops command", n_set, 1);
    start(0); xbyte(8'h04, d); stop(0);
    chk(n_clr == 1, "R2", "clr_wel count", n_clr, 1);

    // R3 / R11: status read repeats
    oe_seen = 0;
    start(0); xbyte(8'h05, d); xbyte(8'h00, got);
    chk(got == 8'hA5, "R3", "status byte 1", got, 8'hA5);
    xbyte(8'h00, got);
    chk(got == 8'hA5, "R3", "status byte 2", got, 8'hA5);
    stop(0);
    chk(oe_seen == 1, "R11", "so_oe during status read", oe_seen, 1);
    chk(so_oe == 0, "R11", "so_oe after deselect", so_oe, 0);

    // R8: status write
    start(0); xbyte(8'h01, d); xbyte(8'h8C, d); stop(0);
    chk(n_sr == 1 && last_sr == 8'h8C, "R8", "sr_wdata", last_sr, 8'h8C);
    start(0); xbyte(8'h01, d); xbyte(8'h33, d); xbit(1, ob); stop(0);
    chk(n_sr == 1, "R8", "sr_wr after extra clock", n_sr, 1);

    // R6: write aborted mid-byte leaves the array untouched
    wbuf[0] = 8'h11; page_write(16'h0300, 1);
    b0 = n_mw;
    start(0); xbyte(8'h02, d); xbyte(8'h03, d); xbyte(8'h00, d);
    xbyte(8'h77, d); xbit(1, ob); xbit(0, ob); xbit(1, ob); stop(0);
    chk(n_mw == b0, "R6", "no request on misaligned deselect", n_mw, b0);
    mem_read(16'h0300, 1, 0);
    chk(rbuf[0] == 8'h11, "R6", "aborted write data", rbuf[0], 8'h11);

    // R7: request without permission
    wbuf[0] = 8'h22; page_write(16'h0301, 1);
    write_allow = 0; b0 = n_mw;
    wbuf[0] = 8'h55; page_write(16'h0301, 1);
    chk(n_mw == b0 + 1, "R7", "mem_wr pulse present", n_mw, b0 + 1);
    write_allow = 1;
    mem_read(16'h0301, 1, 0);
    chk(rbuf[0] == 8'h22, "R7", "denied write data", rbuf[0], 8'h22);

    // R5 / R6: page wrap at top of the array
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hD0 + 8'(i);
    page_write(16'h07FC, 6);
    chk(last_mw == 11'h7FC, "R6", "mem_wr_addr", last_mw, 11'h7FC);
    wbuf[0] = 8'hE0; wbuf[1] = 8'hE1; page_write(16'h0000, 2);
    mem_read(16'h07E0, 2, 0);
    chk(rbuf[0] == 8'hD4 && rbuf[1] == 8'hD5, "R5", "page wrap slot 0",
        rbuf[0], 8'hD4);
    // R4: read wraps across the whole array, upper address bits ignored
    mem_read(16'hF7FE, 4, 0);
    chk(rbuf[0] == 8'hD2 && rbuf[1] == 8'hD3, "R4", "read top bytes", rbuf[1], 8'hD3);
    chk(rbuf[2] == 8'hE0 && rbuf[3] == 8'hE1, "R4", "read wrap to zero", rbuf[2], 8'hE0);
    // R4: idle-high clock framing
    mem_read(16'h07FF, 2, 1);
    chk(rbuf[0] == 8'hD3 && rbuf[1] == 8'hE0, "R4", "idle-high read", rbuf[0], 8'hD3);

    // R5: overwrite inside a page
    for (int i = 0; i < 34; i++) wbuf[i] = 8'h40 + 8'(i);
    page_write(16'h0040, 34);
    mem_read(16'h0040, 3, 0);
    chk(rbuf[0] == 8'h60 && rbuf[1] == 8'h61 && rbuf[2] == 8'h42, "R5",
        "overwritten slots", rbuf[0], 8'h60);

    // R10: unknown command
    oe_seen = 0; b0 = n_set + n_clr + n_sr + n_mw;
    start(0); xbyte(8'h9A, d); xbyte(8'h05, d); xbyte(8'h06, d); stop(0);
    chk(oe_seen == 0, "R10", "no drive after unknown command", oe_seen, 0);
    chk(n_set + n_clr + n_sr + n_mw == b0, "R10", "no request", n_set + n_clr + n_sr + n_mw, b0);

    // R9: pause in the middle of a write data byte
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hB0 + 8'(i);
    start(0); xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h20, d);
    xbyte(wbuf[0], d);
    for (int i = 7; i >= 5; i--) xbit(wbuf[1][i], ob);
    sck = 0; tick(HALF); hold_n = 0; tick(HALF);
    repeat (3) begin sck = 1; si = 1'($urandom); tick(4); sck = 0; tick(4); end
    hold_n = 1; tick(HALF);
    for (int i = 4; i >= 0; i--) xbit(wbuf[1][i], ob);
    xbyte(wbuf[2], d); xbyte(wbuf[3], d); stop(0);
    for (int i = 0; i < 4; i++) begin
      exp_mem[11'h120 + 11'(i)] = wbuf[i]; exp_known[11'h120 + 11'(i)] = 1;
    end
    // R9: pause in the middle of a read data byte
    start(0); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'h20, d);
    for (int i = 7; i >= 5; i--) xbit(0, got[i]);
    sck = 0; tick(HALF); hold_n = 0; tick(HALF);
    chk(so_oe == 0, "R9", "so_oe while paused", so_oe, 0);
    repeat (3) begin sck = 1; si = 1'($urandom); tick(4); sck = 0; tick(4); end
    hold_n = 1; tick(HALF);
    for (int i = 4; i >= 0; i--) xbit(0, got[i]);
    chk(got == 8'hB0, "R9", "read byte across pause", got, 8'hB0);
    xbyte(8'h00, got);
    chk(got == 8'hB1, "R9", "write byte across pause", got, 8'hB1);
    stop(0);

    // Random page writes checked by readback of the whole page
    for (int it = 0; it < 6; it++) begin
      a = 16'($urandom); n = 1 + int'($urandom % 40);
      write_allow = ($urandom % 4) != 0;
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      b0 = n_mw;
      page_write(a, n);
      chk(n_mw == b0 + 1 && last_mw == a[10:0], "R6", "random mem_wr_addr",
          last_mw, a[10:0]);
      write_allow = 1;
      mem_read({a[15:5], 5'd0}, 32, 0);
      for (int i = 0; i < 32; i++)
        if (exp_known[{a[10:5], 5'(i)}])
          chk(rbuf[i] == exp_mem[{a[10:5], 5'(i)}], "R5", "random page byte",
              rbuf[i], exp_mem[{a[10:5], 5'(i)}]);
    end

    done = 1;
    finish_run();
  end
endmodule